// File: doc/BRIEF.md
# Device-Lane Symbol Corrector with Spare Lane

This block guards a 32-bit memory word spread across ten 4-bit device lanes: eight carry data nibbles and two carry check symbols over GF(16). An eleventh physical lane is held in reserve. Because every nibble lives on its own device, a device that loses its entire contents corrupts exactly one symbol, and the code can rebuild that symbol whatever its error pattern. On a write the block computes the two check symbols and stores the row. On a read it computes two syndromes, finds the lane in error, repairs it, or flags the word as beyond repair.

Each logical lane has a saturating count of corrected errors. When a count reaches a programmable threshold, the lane is declared failed. The first failed lane is steered onto the reserve lane for all later traffic, so a device with stuck bits stops using up the correction margin. If a second lane fails while the reserve is taken, the correction margin is gone. The block then raises a sticky fatal flag. From that point it repairs only the known-dead lane and reports any other error as uncorrectable. The storage is a plain row-per-address register file inside the block. Two inputs XOR a pattern into chosen physical lanes on the read path to model device upsets.

Top module: `sym_edac_spare`

## Requirements
- R1: A write stores logical symbol i (i < 8) as wr_data[4i+3:4i] and adds check symbols 8 and 9. With primitive polynomial x^4+x+1 and alpha = 2, the XOR of all ten symbols and the sum of symbol i times alpha^i both come out zero. A read issued in the cycle after the write returns the word.
- R2: rd_valid is high exactly two cycles after a cycle with rd_en high, and at no other time.
- R3: A read whose ten symbols give zero syndromes returns the stored data, with neither corr_pulse nor uncorr_pulse raised.
- R4: A single symbol error in any of the ten logical lanes, with any nonzero 4-bit pattern, is repaired. corr_pulse rises and corr_lane gives the lane, where 0..7 are data and 8..9 are check.
- R5: A word is flagged with uncorr_pulse and its data returned unrepaired when one syndrome is zero and the other is not, or when the located lane is 10 or higher.
- R6: corr_pulse and uncorr_pulse are never high together, and neither is high without rd_valid.
- R7: Each repair adds one to a saturating per-lane count. A repair that brings its lane's count to fail_thresh or above sets bit i of failed_mask, where i is the logical lane. The bit is visible in the same cycle as that read's rd_valid.
- R8: The first failed lane is served from physical lane 10 on every later read and write, and spare_busy goes high. An upset on the lane's old physical position then has no effect, while an upset on physical lane 10 is repaired against that logical lane. Before the spare is taken, an upset on physical lane 10 has no effect.
- R9: A lane that fails while spare_busy is high sets fatal. fatal stays high until clr.
- R10: While fatal is high, a repair is made only when the located lane is the lane that failed without a spare. An error located in any other lane is reported through uncorr_pulse.
- R11: A one-cycle clr zeroes the counts, failed_mask, spare_busy and fatal. Stored rows are kept, and each lane returns to its own physical lane.
- R12: After reset, rd_valid, corr_pulse, uncorr_pulse, spare_busy, failed_mask and fatal are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Clears counts, failures, spare and fatal |
| fail_thresh | input | CNT_W | Repair count that declares a lane failed |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write row |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read row |
| upset_mask | input | 11 | Physical lanes upset on this read (bit 10 is the spare) |
| upset_pat | input | 4 | XOR pattern applied to the upset lanes |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 32 | Repaired or raw read data |
| corr_pulse | output | 1 | One symbol was repaired |
| corr_lane | output | 4 | Logical lane that was repaired |
| uncorr_pulse | output | 1 | Word could not be repaired |
| spare_busy | output | 1 | Spare lane in use |
| failed_mask | output | 10 | Failed logical lanes |
| fatal | output | 1 | Memory inoperable |

## Verification
A write becomes visible to a read sampled one edge later. Read results, together with any change to failed_mask, spare_busy or fatal that the read causes, appear in the cycle after the second edge following rd_en. A new lane mapping first applies to a read sampled at the next edge. The bench's behavioural model advances at every rising edge in that same order: result from the earlier capture first, then read capture, then write, then the health update. Every output is compared against the model at each falling edge, so any result that arrives one cycle early or late is caught.

// File: rtl/edac_pkg.sv
package edac_pkg;
  localparam int SYM_W     = 4;
  localparam int N_DATA    = 8;
  localparam int N_CHK     = 2;
  localparam int N_LOG     = N_DATA + N_CHK;
  localparam int N_PHYS    = N_LOG + 1;
  localparam int SPARE_IDX = N_LOG;
  localparam int LANE_W    = 4;
  localparam int GF_ORDER  = (1 << SYM_W) - 1;
  localparam int DATA_W    = N_DATA * SYM_W;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [N_LOG-1:0][SYM_W-1:0]  cw_t;
  typedef logic [N_PHYS-1:0][SYM_W-1:0] row_t;

  localparam sym_t POLY_LOW = 4'h3;  // x^4 = x + 1

  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[SYM_W-2:0], 1'b0} ^ (sh[SYM_W-1] ? POLY_LOW : sym_t'(0));
    end
    return acc;
  endfunction

  function automatic sym_t gf_apow(int n);
    sym_t r;
    r = sym_t'(1);
    for (int k = 0; k < GF_ORDER; k++)
      if (k < n) r = gf_mul(r, sym_t'(2));
    return r;
  endfunction

  // returns GF_ORDER for zero (no logarithm)
  function automatic sym_t gf_log(sym_t v);
    sym_t r;
    r = sym_t'(GF_ORDER);
    for (int k = GF_ORDER - 1; k >= 0; k--)
      if (gf_apow(k) == v) r = sym_t'(k);
    return r;
  endfunction

  function automatic sym_t gf_inv(sym_t v);
    sym_t r;
    r = '0;
    for (int k = 1; k <= GF_ORDER; k++)
      if (gf_mul(v, sym_t'(k)) == sym_t'(1)) r = sym_t'(k);
    return r;
  endfunction

  function automatic sym_t syn_sum(cw_t c);
    sym_t s;
    s = '0;
    for (int i = 0; i < N_LOG; i++) s = s ^ c[i];
    return s;
  endfunction

  function automatic sym_t syn_wtd(cw_t c);
    sym_t s;
    s = '0;
    for (int i = 0; i < N_LOG; i++) s = s ^ gf_mul(c[i], gf_apow(i));
    return s;
  endfunction

  function automatic cw_t edac_encode(logic [DATA_W-1:0] d);
    cw_t  c;
    sym_t d0, d1, lo, hi;
    d0 = '0;
    d1 = '0;
    for (int i = 0; i < N_DATA; i++) begin
      c[i] = d[i*SYM_W +: SYM_W];
      d0   = d0 ^ c[i];
      d1   = d1 ^ gf_mul(c[i], gf_apow(i));
    end
    // lo + hi = d0 ; a^N lo + a^(N+1) hi = d1
    lo = gf_mul(gf_inv(gf_apow(N_DATA) ^ gf_apow(N_DATA + 1)),
                d1 ^ gf_mul(gf_apow(N_DATA + 1), d0));
    hi = d0 ^ lo;
    c[N_DATA]     = lo;
    c[N_DATA + 1] = hi;
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] cw_data(cw_t c);
    logic [DATA_W-1:0] d;
    for (int i = 0; i < N_DATA; i++) d[i*SYM_W +: SYM_W] = c[i];
    return d;
  endfunction
endpackage

// File: rtl/sym_encoder.sv
module sym_encoder
  import edac_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output cw_t               cw_o
);
  always_comb cw_o = edac_encode(data_i);

  // a freshly encoded row is a codeword
  always_comb begin
    if (!$isunknown(data_i))
      assert_enc_codeword_R1: assert (syn_sum(cw_o) == '0 && syn_wtd(cw_o) == '0);
  end
endmodule

// File: rtl/sym_decoder.sv
module sym_decoder
  import edac_pkg::*;
(
  input  cw_t               cw_i,
  input  logic              hole_on,
  input  logic [LANE_W-1:0] hole_lane,
  output logic [DATA_W-1:0] data_o,
  output logic              corr_o,
  output logic              uncorr_o,
  output logic [LANE_W-1:0] loc_o
);
  sym_t s_sum, s_wtd, quot, loc;
  logic in_range, single, clean;
  cw_t  fixed;

  always_comb begin
    s_sum    = syn_sum(cw_i);
    s_wtd    = syn_wtd(cw_i);
    quot     = gf_mul(s_wtd, gf_inv(s_sum));
    loc      = gf_log(quot);
    in_range = (loc < sym_t'(N_LOG));
    clean    = (s_sum == '0) && (s_wtd == '0);
    single   = (s_sum != '0) && (s_wtd != '0) && in_range;
    corr_o   = single && (!hole_on || loc == hole_lane);
    uncorr_o = !clean && !corr_o;
    loc_o    = loc;
    for (int l = 0; l < N_LOG; l++)
      fixed[l] = cw_i[l] ^ ((corr_o && loc == sym_t'(l)) ? s_sum : sym_t'(0));
    data_o = cw_data(fixed);
  end
endmodule

// File: rtl/lane_health.sv
module lane_health
  import edac_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [CNT_W-1:0]  thresh_i,
  input  logic              ev_ok,
  input  logic [LANE_W-1:0] ev_lane,
  output logic [N_LOG-1:0]  failed_o,
  output logic              spare_o,
  output logic [LANE_W-1:0] spare_lane_o,
  output logic              fatal_o,
  output logic [LANE_W-1:0] hole_lane_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [N_LOG];
  logic [CNT_W-1:0] cnt_sel, cnt_inc;
  logic             failed_sel, lane_dead;
  logic [N_LOG-1:0] lane_bit;

  always_comb begin
    cnt_sel    = '0;
    failed_sel = 1'b0;
    lane_bit   = '0;
    for (int l = 0; l < N_LOG; l++)
      if (ev_lane == LANE_W'(l)) begin
        cnt_sel     = cnt_q[l];
        failed_sel  = failed_o[l];
        lane_bit[l] = 1'b1;
      end
    cnt_inc   = (cnt_sel == CNT_MAX) ? cnt_sel : cnt_sel + 1'b1;
    lane_dead = ev_ok && (cnt_inc >= thresh_i) && !failed_sel;
  end

  for (genvar g = 0; g < N_LOG; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n || clr)                               cnt_q[g] <= '0;
      else if (ev_ok && ev_lane == LANE_W'(g) && cnt_q[g] != CNT_MAX) cnt_q[g] <= cnt_q[g] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      failed_o     <= '0;
      spare_o      <= 1'b0;
      spare_lane_o <= '0;
      fatal_o      <= 1'b0;
      hole_lane_o  <= '0;
    end else if (lane_dead) begin
      failed_o <= failed_o | lane_bit;
      if (!spare_o) begin
        spare_o      <= 1'b1;
        spare_lane_o <= ev_lane;
      end else begin
        fatal_o <= 1'b1;
        if (!fatal_o) hole_lane_o <= ev_lane;
      end
    end
  end

  assert_spare_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (spare_o && !clr) |=> (spare_o && spare_lane_o == $past(spare_lane_o)));
  assert_fatal_two_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fatal_o) |-> ($countones(failed_o) >= 2));
  assert_fatal_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fatal_o && !clr) |=> fatal_o);
  assert_clr_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (failed_o == '0 && !spare_o && !fatal_o));
endmodule

// File: rtl/sym_edac_spare.sv
module sym_edac_spare
  import edac_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [CNT_W-1:0]  fail_thresh,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [10:0]       upset_mask,
  input  logic [3:0]        upset_pat,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              corr_pulse,
  output logic [3:0]        corr_lane,
  output logic              uncorr_pulse,
  output logic              spare_busy,
  output logic [9:0]        failed_mask,
  output logic              fatal
);
  localparam int DEPTH = 1 << ADDR_W;

  row_t              mem [DEPTH];
  cw_t               wr_cw, rd_cw, s1_cw;
  row_t              wr_row, rd_row;
  logic              s1_valid;
  logic [LANE_W-1:0] spare_lane, hole_lane, dec_loc;
  logic [DATA_W-1:0] dec_data;
  logic              dec_corr, dec_uncorr, ev_ok;

  sym_encoder u_enc (.data_i(wr_data), .cw_o(wr_cw));

  // write: every logical lane to its own device, spared lane mirrored to the reserve
  always_comb begin
    wr_row = '0;
    for (int p = 0; p < N_LOG; p++) wr_row[p] = wr_cw[p];
    for (int l = 0; l < N_LOG; l++)
      if (spare_busy && spare_lane == LANE_W'(l)) wr_row[SPARE_IDX] = wr_cw[l];
  end

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_row;

  // read: device upsets, then gather logical lanes through the remap
  always_comb begin
    for (int p = 0; p < N_PHYS; p++)
      rd_row[p] = mem[rd_addr][p] ^ (upset_mask[p] ? upset_pat : sym_t'(0));
    for (int l = 0; l < N_LOG; l++)
      rd_cw[l] = (spare_busy && spare_lane == LANE_W'(l)) ? rd_row[SPARE_IDX] : rd_row[l];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_cw    <= '0;
    end else begin
      s1_valid <= rd_en;
      if (rd_en) s1_cw <= rd_cw;
    end
  end

  sym_decoder u_dec (
    .cw_i(s1_cw), .hole_on(fatal), .hole_lane(hole_lane),
    .data_o(dec_data), .corr_o(dec_corr), .uncorr_o(dec_uncorr), .loc_o(dec_loc)
  );

  assign ev_ok = s1_valid && dec_corr;

  lane_health #(.CNT_W(CNT_W)) u_health (
    .clk(clk), .rst_n(rst_n), .clr(clr), .thresh_i(fail_thresh),
    .ev_ok(ev_ok), .ev_lane(dec_loc),
    .failed_o(failed_mask), .spare_o(spare_busy), .spare_lane_o(spare_lane),
    .fatal_o(fatal), .hole_lane_o(hole_lane)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      corr_pulse   <= 1'b0;
      corr_lane    <= '0;
      uncorr_pulse <= 1'b0;
    end else begin
      rd_valid     <= s1_valid;
      corr_pulse   <= ev_ok;
      uncorr_pulse <= s1_valid && dec_uncorr;
      if (s1_valid) begin
        rd_data   <= dec_data;
        corr_lane <= dec_loc;
      end
    end
  end

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ##2 rd_valid);
  assert_valid_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en, 2));
  assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(corr_pulse && uncorr_pulse));
  assert_flags_qual_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_pulse || uncorr_pulse) |-> rd_valid);
  assert_lane_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    corr_pulse |-> (corr_lane < LANE_W'(N_LOG)));
  assert_spare_failed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spare_busy |-> (failed_mask[spare_lane] == 1'b1));
  assert_hole_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && fatal && dec_corr) |-> (dec_loc == hole_lane));
endmodule

// File: tb/sim_sym_edac_spare.sv
module sim_sym_edac_spare;
  localparam int ADDR_W = 4;
  localparam int CNT_W  = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0, clr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [CNT_W-1:0] fail_thresh = '1;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [10:0] upset_mask = '0;
  logic [3:0]  upset_pat = '0;
  logic rd_valid, corr_pulse, uncorr_pulse, spare_busy, fatal;
  logic [31:0] rd_data;
  logic [3:0]  corr_lane;
  logic [9:0]  failed_mask;

  always #10 clk = ~clk;  // 50 MHz

  sym_edac_spare #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fail_thresh(fail_thresh),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .upset_mask(upset_mask), .upset_pat(upset_pat),
    .rd_valid(rd_valid), .rd_data(rd_data), .corr_pulse(corr_pulse), .corr_lane(corr_lane),
    .uncorr_pulse(uncorr_pulse), .spare_busy(spare_busy), .failed_mask(failed_mask), .fatal(fatal)
  );

  // ---------- GF(16) via exp/log tables ----------
  int gexp[15];
  int glog[16];
  initial begin
    int v;
    v = 1;
    for (int i = 0; i < 15; i++) begin
      gexp[i] = v; glog[v] = i;
      v = v << 1;
      if (v & 16) v = v ^ 'h13;
    end
  end
  function automatic int bmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return gexp[(glog[a] + glog[b]) % 15];
  endfunction

  // ---------- reference model ----------
  int pm [DEPTH][11];
  int p1 [10];
  int p1_v, e_v, e_corr, e_lane, e_unc;
  logic [31:0] e_data;
  int m_cnt [10];
  logic [9:0] m_failed;
  int m_spare, m_sl, m_fatal, m_hole;
  int n_chk = 0, n_fail = 0;
  string phase = "R12 reset";
  bit seen_edge = 0;

  always @(posedge clk) begin : model
    int s0, s1, loc, ph, v, sy[10], fx[10];
    bit found;
    seen_edge = 1;
    if (!rst_n) begin
      p1_v = 0; e_v = 0; e_corr = 0; e_unc = 0; e_lane = 0; e_data = 0;
      for (int l = 0; l < 10; l++) m_cnt[l] = 0;
      m_failed = 0; m_spare = 0; m_sl = 0; m_fatal = 0; m_hole = 0;
    end else begin
      // result of the earlier capture
      e_v = p1_v; e_corr = 0; e_unc = 0;
      if (p1_v) begin
        s0 = 0; s1 = 0;
        for (int i = 0; i < 10; i++) begin s0 ^= p1[i]; s1 ^= bmul(p1[i], gexp[i]); fx[i] = p1[i]; end
        loc = 15;
        if (s0 != 0 && s1 != 0)
          for (int j = 0; j < 15; j++) if (bmul(s0, gexp[j]) == s1) loc = j;
        if (s0 == 0 && s1 == 0) ;
        else if (loc < 10 && (!m_fatal || loc == m_hole)) begin
          e_corr = 1; e_lane = loc; fx[loc] ^= s0;
        end else e_unc = 1;
        for (int i = 0; i < 8; i++) e_data[i*4 +: 4] = fx[i][3:0];
      end
      // capture
      p1_v = rd_en;
      if (rd_en)
        for (int l = 0; l < 10; l++) begin
          ph = (m_spare && m_sl == l) ? 10 : l;
          v = pm[rd_addr][ph];
          if (upset_mask[ph]) v ^= upset_pat;
          p1[l] = v;
        end
      // write: brute-force check symbols
      if (wr_en) begin
        for (int i = 0; i < 8; i++) sy[i] = wr_data[i*4 +: 4];
        found = 0;
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++) begin
            sy[8] = a; sy[9] = b; s0 = 0; s1 = 0;
            for (int i = 0; i < 10; i++) begin s0 ^= sy[i]; s1 ^= bmul(sy[i], gexp[i]); end
            if (!found && s0 == 0 && s1 == 0) begin found = 1; fx[8] = a; fx[9] = b; end
          end
        sy[8] = fx[8]; sy[9] = fx[9];
        for (int l = 0; l < 10; l++) pm[wr_addr][l] = sy[l];
        pm[wr_addr][10] = m_spare ? sy[m_sl] : 0;
      end
      // health
      if (clr) begin
        for (int l = 0; l < 10; l++) m_cnt[l] = 0;
        m_failed = 0; m_spare = 0; m_sl = 0; m_fatal = 0; m_hole = 0;
      end else if (e_corr) begin
        if (m_cnt[e_lane] < CMAX) m_cnt[e_lane]++;
        if (m_cnt[e_lane] >= int'(fail_thresh) && !m_failed[e_lane]) begin
          m_failed[e_lane] = 1'b1;
          if (!m_spare) begin m_spare = 1; m_sl = e_lane; end
          else begin
            if (!m_fatal) m_hole = e_lane;
            m_fatal = 1;
          end
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] t=%0t: actual %0h expected %0h", tag, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (seen_edge) begin
    chk(rd_valid == e_v[0], "R2 rd_valid", rd_valid, e_v);
    if (e_v) chk(rd_data == e_data, e_corr ? "R4 rd_data" : (e_unc ? "R5 rd_data" : "R3 rd_data"), rd_data, e_data);
    chk(corr_pulse == e_corr[0], "R4 corr_pulse", corr_pulse, e_corr);
    if (e_corr) chk(corr_lane == e_lane[3:0], "R4 corr_lane", corr_lane, e_lane);
    chk(uncorr_pulse == e_unc[0], "R5 uncorr_pulse", uncorr_pulse, e_unc);
    chk(!(corr_pulse && uncorr_pulse), "R6 exclusive", {corr_pulse, uncorr_pulse}, 0);
    chk(failed_mask == m_failed, "R7 failed_mask", failed_mask, m_failed);
    chk(spare_busy == m_spare[0], "R8 spare_busy", spare_busy, m_spare);
    chk(fatal == m_fatal[0], "R9 fatal", fatal, m_fatal);
  end

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1; wr_addr = a[ADDR_W-1:0]; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(input int a, input logic [10:0] m, input logic [3:0] p);
    rd_en = 1; rd_addr = a[ADDR_W-1:0]; upset_mask = m; upset_pat = p;
    @(negedge clk); rd_en = 0; upset_mask = 0; upset_pat = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_clr();
    clr = 1; @(negedge clk); clr = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    phase = "R12 reset";
    idle(1);
    rst_n = 1;
    idle(1);

    phase = "R1 R3 clean";
    fail_thresh = 4'd15;
    for (int i = 0; i < 10; i++) wr(i, (32'h9E37_79B9 * (i + 1)) ^ (i << 28));
    wr(10, 32'h0); wr(11, 32'hFFFF_FFFF);
    for (int i = 0; i < 12; i++) rd(i, 0, 0);
    wr(12, 32'hA5A5_5A5A); rd(12, 0, 0);  // read right after write

    phase = "R4 single";
    for (int l = 0; l < 10; l++) begin
      rd(l, 11'(1 << l), 4'h1);
      rd(l, 11'(1 << l), 4'h8);
      rd(l, 11'(1 << l), 4'hF);
    end
    phase = "R8 spare idle";
    rd(3, 11'h400, 4'h7);

    phase = "R5 double";
    rd(1, 11'b000_0000_1001, 4'h5);
    rd(2, 11'b000_0000_0011, 4'hF);
    rd(3, 11'b010_0001_0000, 4'h7);
    rd(4, 11'h3FF, 4'h1);
    rd(5, 11'b001_1000_0000, 4'hC);
    rd(6, 11'b000_0110_0000, 4'h2);
    idle(3);

    phase = "R11 clear";
    pulse_clr();
    idle(2);

    phase = "R7 R8 threshold";
    fail_thresh = 4'd3;
    rd(5, 11'(1 << 2), 4'h6);
    rd(5, 11'(1 << 2), 4'h6);
    rd(5, 11'(1 << 2), 4'h6);
    idle(3);
    wr(0, 32'hC0DE_F00D);
    phase = "R8 remapped";
    rd(0, 11'(1 << 2), 4'h9);
    rd(0, 11'h400, 4'h9);
    idle(3);

    phase = "R9 second failure";
    rd(0, 11'(1 << 5), 4'h3);
    rd(0, 11'(1 << 5), 4'h3);
    rd(0, 11'(1 << 5), 4'h3);
    idle(3);
    phase = "R10 margin used";
    rd(0, 11'(1 << 1), 4'h4);
    rd(0, 11'(1 << 5), 4'h4);
    rd(0, 11'(1 << 9), 4'hB);
    idle(3);

    phase = "R11 clear";
    pulse_clr();
    idle(2);
    rd(0, 0, 0);
    rd(0, 11'(1 << 2), 4'h1);
    rd(5, 0, 0);
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule